// File: doc/BRIEF.md
# Function-Coded Integer ALU with Bidirectional Shifter

This block is a purely combinational 32-bit arithmetic and logic unit. A 5-bit function code picks one of four result sources. The first is a two's-complement adder/subtractor. The second is a set-less-than compare that returns a single bit. The third is a barrel shifter that moves operand B by a distance taken from operand A. The fourth is a per-bit logic unit. The block also drives four condition flags: zero, negative, carry and overflow.

The function code is packed as `funcCode[4]` = subtract select, `funcCode[3:2]` = a 2-bit variant select, `funcCode[1]` = shift select and `funcCode[0]` = arithmetic select. The variant select steers the shifter kind, the logic function and the compare signedness. The adder runs for every code, so the negative, carry and overflow flags always describe the adder's output. The zero flag always describes the result that leaves the block.

Top module: `aluCore`

## Requirements
- R1: With funcCode[0]=1, funcCode[1]=0 and funcCode[4]=0, result is opA+opB modulo 2^32, whatever the value of funcCode[3:2].
- R2: With funcCode[0]=1, funcCode[1]=0 and funcCode[4]=1, result is opA-opB modulo 2^32, whatever the value of funcCode[3:2].
- R3: With funcCode[0]=1, funcCode[1]=1 and funcCode[2]=0, result bit 0 is 1 exactly when opA is less than opB as signed numbers. The subtractor is engaged even when funcCode[4]=0.
- R4: With funcCode[0]=1, funcCode[1]=1 and funcCode[2]=1, result bit 0 is 1 exactly when opA is less than opB as unsigned numbers.
- R5: For every compare code (funcCode[1:0]=11), result bits 31..1 are 0.
- R6: With funcCode[0]=0, funcCode[1]=1 and funcCode[3:2]=00, result is opB shifted left by opA[4:0], with zeros filled in. opA[31:5] has no effect.
- R7: With funcCode[0]=0, funcCode[1]=1 and funcCode[3:2] equal to 01 or 10, result is opB shifted right by opA[4:0], with zeros filled in.
- R8: With funcCode[0]=0, funcCode[1]=1 and funcCode[3:2]=11, result is opB shifted right by opA[4:0], with copies of opB[31] filled in.
- R9: With funcCode[1:0]=00, each result bit is a function of opA and opB at the same position: funcCode[3:2] 00 gives AND, 01 gives OR, 10 gives XOR and 11 gives NOR.
- R10: zFlag is 1 exactly when the selected 32-bit result is zero, for every function code.
- R11: nFlag, cFlag and vFlag come from the adder for every code. The adder computes opA+opB, or opA-opB when funcCode[4]=1 or funcCode[1:0]=11. nFlag is the adder's bit 31. cFlag is the carry out of opA + (opB or ~opB) + sub. vFlag is two's-complement overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand; its low 5 bits give the shift distance |
| opB | input | 32 | Second operand; the value that is shifted |
| funcCode | input | 5 | Operation select {sub, variant[1:0], shift, arith} |
| result | output | 32 | Selected result |
| zFlag | output | 1 | Selected result is zero |
| nFlag | output | 1 | Adder result is negative |
| cFlag | output | 1 | Carry out of the adder |
| vFlag | output | 1 | Signed overflow of the adder |

## Verification
In a compare operation, two things happen in one evaluation. The subtractor produces the carry, negative and overflow flags, and the compare collapses the result to a single bit that feeds the zero flag. The two can disagree: for example, equal operands give a zero result, so the zero flag is 1 while the carry flag is also 1. The bench provokes this by sweeping every one of the 32 codes across corner operands (0, all ones, the most negative and most positive values, and shift distances 0 and 31) and across random pairs. Each cycle's result and all four flags are compared against a reference model written from the requirements.

// File: rtl/aluPkg.sv
package aluPkg;
  typedef enum logic [1:0] {
    SEL_BOOL  = 2'd0,
    SEL_SHIFT = 2'd1,
    SEL_SUM   = 2'd2,
    SEL_CMP   = 2'd3
  } resSel_e;

  typedef struct packed {
    resSel_e    resSel;
    logic       doSub;
    logic       cmpUnsigned;
    logic       shiftLeft;
    logic       shiftArith;
    logic [1:0] boolFn;
  } aluCtrl_t;
endpackage

// File: rtl/aluDecode.sv
module aluDecode
  import aluPkg::*;
(
  input  logic [4:0] funcCode,
  output aluCtrl_t   ctrl
);
  logic       subBit;
  logic [1:0] variant;
  logic       shftBit;
  logic       mathBit;

  assign subBit  = funcCode[4];
  assign variant = funcCode[3:2];
  assign shftBit = funcCode[1];
  assign mathBit = funcCode[0];

  always_comb begin
    ctrl             = '0;
    ctrl.boolFn      = variant;
    ctrl.cmpUnsigned = variant[0];
    ctrl.shiftLeft   = (variant == 2'b00);
    ctrl.shiftArith  = (variant == 2'b11);
    ctrl.doSub       = subBit | (mathBit & shftBit);
    unique case ({mathBit, shftBit})
      2'b00:   ctrl.resSel = SEL_BOOL;
      2'b01:   ctrl.resSel = SEL_SHIFT;
      2'b10:   ctrl.resSel = SEL_SUM;
      default: ctrl.resSel = SEL_CMP;
    endcase
  end
endmodule

// File: rtl/aluAddSub.sv
module aluAddSub #(
  parameter int W = 32
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic         doSub,
  output logic [W-1:0] sum,
  output logic         carryOut,
  output logic         negOut,
  output logic         ovfOut
);
  logic [W-1:0] bEff;
  logic [W:0]   wide;

  assign bEff     = doSub ? ~inB : inB;
  assign wide     = {1'b0, inA} + {1'b0, bEff} + {{W{1'b0}}, doSub};
  assign sum      = wide[W-1:0];
  assign carryOut = wide[W];
  assign negOut   = wide[W-1];
  assign ovfOut   = (inA[W-1] == bEff[W-1]) && (wide[W-1] != inA[W-1]);
endmodule

// File: rtl/aluShifter.sv
module aluShifter #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   shIn,
  input  logic [SHW-1:0] shAmt,
  input  logic           toLeft,
  input  logic           arith,
  output logic [W-1:0]   shOut
);
  logic [W-1:0] stage [SHW+1];
  logic [W-1:0] revIn;
  logic [W-1:0] revOut;
  logic         fillBit;

  generate
    for (genvar i = 0; i < W; i++) begin : g_rev
      assign revIn[i]  = shIn[W-1-i];
      assign revOut[i] = stage[SHW][W-1-i];
    end
  endgenerate

  assign fillBit  = arith & ~toLeft & shIn[W-1];
  assign stage[0] = toLeft ? revIn : shIn;

  generate
    for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int STEP = 1 << k;
      assign stage[k+1] = shAmt[k]
        ? {{STEP{fillBit}}, stage[k][W-1:STEP]}
        : stage[k];
    end
  endgenerate

  assign shOut = toLeft ? revOut : stage[SHW];
endmodule

// File: rtl/aluBoolUnit.sv
module aluBoolUnit #(
  parameter int W = 32
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [1:0]   fnSel,
  output logic [W-1:0] boolOut
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic [3:0] gateOut;
      assign gateOut[0] = inA[i] & inB[i];
      assign gateOut[1] = inA[i] | inB[i];
      assign gateOut[2] = inA[i] ^ inB[i];
      assign gateOut[3] = ~(inA[i] | inB[i]);
      assign boolOut[i] = gateOut[fnSel];
    end
  endgenerate
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluCtrl_t     ctrl,
  output logic [W-1:0] result,
  output logic         nFlag,
  output logic         cFlag,
  output logic         vFlag
);
  localparam int SHW = $clog2(W);

  logic [W-1:0] sumVal;
  logic [W-1:0] shiftVal;
  logic [W-1:0] boolVal;
  logic         lessBit;

  aluAddSub #(.W(W)) uAdd (
    .inA(opA), .inB(opB), .doSub(ctrl.doSub),
    .sum(sumVal), .carryOut(cFlag), .negOut(nFlag), .ovfOut(vFlag)
  );

  aluShifter #(.W(W), .SHW(SHW)) uShift (
    .shIn(opB), .shAmt(opA[SHW-1:0]),
    .toLeft(ctrl.shiftLeft), .arith(ctrl.shiftArith), .shOut(shiftVal)
  );

  aluBoolUnit #(.W(W)) uBool (
    .inA(opA), .inB(opB), .fnSel(ctrl.boolFn), .boolOut(boolVal)
  );

  assign lessBit = ctrl.cmpUnsigned ? ~cFlag : (nFlag ^ vFlag);

  always_comb begin
    unique case (ctrl.resSel)
      SEL_SUM:   result = sumVal;
      SEL_CMP:   result = {{(W-1){1'b0}}, lessBit};
      SEL_SHIFT: result = shiftVal;
      default:   result = boolVal;
    endcase
  end
endmodule

// File: rtl/aluCore.sv
module aluCore
  import aluPkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [4:0]   funcCode,
  output logic [W-1:0] result,
  output logic         zFlag,
  output logic         nFlag,
  output logic         cFlag,
  output logic         vFlag
);
  aluCtrl_t ctrl;

  aluDecode uDec (.funcCode(funcCode), .ctrl(ctrl));

  aluDatapath #(.W(W)) uDp (
    .opA(opA), .opB(opB), .ctrl(ctrl),
    .result(result), .nFlag(nFlag), .cFlag(cFlag), .vFlag(vFlag)
  );

  assign zFlag = ~|result;
endmodule

// File: rtl/aluCoreChecker.sv
module aluCoreChecker #(
  parameter int W = 32
) (
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [4:0]   funcCode,
  input logic [W-1:0] result,
  input logic         zFlag
);
  localparam int SHW = $clog2(W);

  always_comb begin
    if (funcCode[1:0] == 2'b01 && funcCode[4] == 1'b0)
      assert_add_inverse_R1: assert (result - opB == opA);
    if (funcCode[1:0] == 2'b01 && funcCode[4] == 1'b1)
      assert_sub_inverse_R2: assert (result + opB == opA);
    if (funcCode[1:0] == 2'b11)
      assert_cmp_upper_zero_R5: assert (result[W-1:1] == '0);
    if (funcCode[1:0] == 2'b10 && funcCode[3:2] == 2'b00 && opA[SHW-1:0] != '0)
      assert_sll_low_clear_R6: assert (result[0] == 1'b0);
    if (funcCode[1:0] == 2'b10 && funcCode[3:2] == 2'b11)
      assert_sra_sign_kept_R8: assert (result[W-1] == opB[W-1]);
    if (funcCode[1:0] == 2'b00 && funcCode[3:2] == 2'b11)
      assert_nor_disjoint_R9: assert ((result & (opA | opB)) == '0);
    if (zFlag)
      assert_zero_means_zero_R10: assert (result == '0);
  end
endmodule

bind aluCore aluCoreChecker #(.W(W)) uChk (
  .opA(opA), .opB(opB), .funcCode(funcCode), .result(result), .zFlag(zFlag)
);

// File: tb/tb_aluCore.sv
module tb_aluCore;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  funcCode = '0;
  logic [31:0] result;
  logic        zFlag, nFlag, cFlag, vFlag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] a, b;
    logic [4:0]  fn;
    logic [31:0] res;
    logic        z, n, c, v;
  } expItem_t;

  expItem_t sb[$];

  always #2.5 clk = ~clk;

  aluCore dut (
    .opA(opA), .opB(opB), .funcCode(funcCode), .result(result),
    .zFlag(zFlag), .nFlag(nFlag), .cFlag(cFlag), .vFlag(vFlag)
  );

  function automatic string resTag(logic [4:0] fn);
    if (fn[1:0] == 2'b01) return fn[4] ? "R2" : "R1";
    if (fn[1:0] == 2'b11) return fn[2] ? "R4/R5" : "R3/R5";
    if (fn[1:0] == 2'b10) begin
      if (fn[3:2] == 2'b00) return "R6";
      if (fn[3:2] == 2'b11) return "R8";
      return "R7";
    end
    return "R9";
  endfunction

  function automatic expItem_t model(logic [31:0] a, logic [31:0] b, logic [4:0] fn);
    expItem_t e;
    logic        sub;
    logic [31:0] bx;
    logic [32:0] wide;
    logic [4:0]  amt;
    e.a = a; e.b = b; e.fn = fn;
    sub  = fn[4] | (fn[1] & fn[0]);
    bx   = sub ? ~b : b;
    wide = {1'b0, a} + {1'b0, bx} + 33'(sub);
    e.n  = wide[31];
    e.c  = wide[32];
    e.v  = (a[31] == bx[31]) && (wide[31] != a[31]);
    amt  = a[4:0];
    case (fn[1:0])
      2'b01: e.res = fn[4] ? a - b : a + b;
      2'b11: e.res = fn[2] ? {31'd0, a < b} : {31'd0, $signed(a) < $signed(b)};
      2'b10: case (fn[3:2])
               2'b00:   e.res = b << amt;
               2'b11:   e.res = 32'($signed(b) >>> amt);
               default: e.res = b >> amt;
             endcase
      default: case (fn[3:2])
               2'b00:   e.res = a & b;
               2'b01:   e.res = a | b;
               2'b10:   e.res = a ^ b;
               default: e.res = ~(a | b);
             endcase
    endcase
    e.z = (e.res == 32'd0);
    return e;
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [4:0] fn);
    @(posedge clk);
    #1;
    opA = a; opB = b; funcCode = fn;
    sb.push_back(model(a, b, fn));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: compare after the combinational outputs settle
  always @(negedge clk) begin
    if (rstN && sb.size() > 0) begin
      expItem_t e;
      e = sb.pop_front();
      checks++;
      if (result !== e.res) begin
        failures++;
        $display("FAIL %s fn=%b a=%h b=%h result actual=%h expected=%h",
                 resTag(e.fn), e.fn, e.a, e.b, result, e.res);
      end
      checks++;
      if (zFlag !== e.z) begin
        failures++;
        $display("FAIL R10 fn=%b a=%h b=%h zFlag actual=%b expected=%b",
                 e.fn, e.a, e.b, zFlag, e.z);
      end
      checks++;
      if ({nFlag, cFlag, vFlag} !== {e.n, e.c, e.v}) begin
        failures++;
        $display("FAIL R11 fn=%b a=%h b=%h nFlag/cFlag/vFlag actual=%b%b%b expected=%b%b%b",
                 e.fn, e.a, e.b, nFlag, cFlag, vFlag, e.n, e.c, e.v);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finishRun();
    end
  end

  initial begin
    logic [31:0] edges [7];
    edges[0] = 32'h0000_0000;
    edges[1] = 32'hFFFF_FFFF;
    edges[2] = 32'h8000_0000;
    edges[3] = 32'h7FFF_FFFF;
    edges[4] = 32'h0000_0001;
    edges[5] = 32'h0000_0020;  // shift distance 0 with upper bits set (R6)
    edges[6] = 32'h0000_001F;  // shift distance 31
    repeat (3) @(posedge clk);
    #1;
    // Idle state: all-zero inputs select AND, giving a zero result
    checks++;
    if (result !== 32'd0 || zFlag !== 1'b1) begin
      failures++;
      $display("FAIL R9/R10 idle result actual=%h/%b expected=00000000/1", result, zFlag);
    end
    rstN = 1'b1;
    for (int f = 0; f < 32; f++) begin
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          drive(edges[i], edges[j], 5'(f));
      for (int r = 0; r < 40; r++)
        drive($urandom, $urandom, 5'(f));
      // Upper opA bits beyond the distance field must not matter (R6, R7, R8)
      drive({$urandom, 5'd0} | 32'd3, 32'hC000_0F0F, 5'(f));
    end
    // Bool bits ignored for add/sub (R1, R2): same operands, every variant
    for (int f = 0; f < 4; f++) begin
      drive(32'h1234_5678, 32'h0FED_CBA9, {1'b0, 2'(f), 2'b01});
      drive(32'h1234_5678, 32'h0FED_CBA9, {1'b1, 2'(f), 2'b01});
    end
    // Compare with sub bit clear still subtracts (R3, R4)
    drive(32'hFFFF_FFFF, 32'h0000_0001, 5'b00011);
    drive(32'hFFFF_FFFF, 32'h0000_0001, 5'b00111);
    drive(32'h8000_0000, 32'h7FFF_FFFF, 5'b10011);
    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule